// File: doc/BRIEF.md
# Serial Flash Block Protection Controller

This block holds the status and configuration registers that govern write protection in a serial NOR flash, and it decides whether each program or erase request may reach the array. A command front end hands it already-decoded commands, one per cycle, on a valid strobe. Commands that touch the registers carry the new status byte and configuration byte. Commands that touch the array carry a byte address. An active-low write-protect pin is sampled together with each command.

The protected region is a power-of-two share of the array, chosen by a 3-bit code, and sits at either the high or the low end of the address space. Two configuration bits are one-time-programmable. One of them picks the end of the array where the region sits. The other decides whether the protect code survives a power cycle or reloads as "everything protected". A lock bit freezes all protection settings until a hardware reset or a modelled power-on reset. The fabric reset `rst` puts every register, nonvolatile ones included, into the blank-part state. The power-on reset command `CMD_POR` models a power cycle, and the nonvolatile bits keep their values through it.

Command codes on `cmd_op`: 0 no-op, 1 write enable, 2 write disable, 3 write registers, 4 program, 5 erase, 6 software reset, 7 hardware reset, 8 power-on reset. The write-in-progress bit reads 0 because no array is modelled.

Top module: `flash_bp_ctrl`

## Requirements
- R1: With the top/bottom selector at 0, protect code k from 1 to 6 protects the highest 2^(ADDR_W-7+k) bytes. Code 0 protects nothing and code 7 protects every address.
- R2: With the top/bottom selector at 1, the same code protects the same amount of memory, counted from address 0 upward.
- R3: In the cycle after a program or erase request, exactly one of `grant` or `reject` is high. `reject` goes high when the address is protected. A rejected program sets status bit 6 and a rejected erase sets status bit 5. Both bits are sticky.
- R4: Configuration bit 5 (top/bottom selector) and bit 3 (volatility select) can go from 0 to 1 by a register write and never return to 0.
- R5: On a power-on reset command, the protect code (status bits 4..2) loads 111 if configuration bit 3 is 1, and keeps its value if bit 3 is 0.
- R6: While configuration bit 0 (lock) is 1, a register write that would change the protect code, bit 5 or bit 3 changes nothing and pulses `reg_err` for one cycle.
- R7: The lock bit is set by a register write, is cleared only by a hardware-reset or power-on-reset command, and is unaffected by a software reset.
- R8: Status bit 1 (write enable latch) is set by write enable and cleared by write disable or any reset command. A register write while it is 0 has no effect, and a register write never changes it.
- R9: While status bit 7 is 1 and `wp_n` is low, register writes are ignored.
- R10: After `rst` the status byte, configuration byte, `grant`, `reject` and `reg_err` are all 0.
- R11: A power-on reset command clears status bits 6 and 5 and the lock bit. It keeps status bit 7 and configuration bits 5 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high fabric reset to the blank-part state |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_sr | input | 8 | New status byte for a register write |
| cmd_cr | input | 8 | New configuration byte for a register write |
| cmd_addr | input | ADDR_W | Byte address for program or erase |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Status register |
| config_reg | output | 8 | Configuration register |
| grant | output | 1 | Previous request may proceed |
| reject | output | 1 | Previous request hit the protected range |
| reg_err | output | 1 | Previous register write failed because of the lock |

## Verification
The properties assume that at most one command arrives per cycle and that `cmd_op` carries one of the nine defined codes whenever `cmd_valid` is high. The stimulus drives a single command for one cycle and then returns the strobe to idle. It uses only the listed codes, and it changes `wp_n` only between commands. Address sweeps place probes on both sides of each region boundary, so the range check is exercised exactly where an off-by-one would show.

// File: rtl/flash_bp_pkg.sv
package flash_bp_pkg;
  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_WREN  = 4'd1,
    CMD_WRDI  = 4'd2,
    CMD_WRR   = 4'd3,
    CMD_PROG  = 4'd4,
    CMD_ERASE = 4'd5,
    CMD_SWRST = 4'd6,
    CMD_HWRST = 4'd7,
    CMD_POR   = 4'd8
  } cmd_e;

  localparam int BP_W   = 3;
  localparam int SR_LCK = 7;
  localparam int SR_PE  = 6;
  localparam int SR_EE  = 5;
  localparam int SR_BPH = 4;
  localparam int SR_BPL = 2;
  localparam int SR_WEL = 1;
  localparam int CR_BOT = 5;
  localparam int CR_VOL = 3;
  localparam int CR_FRZ = 0;
endpackage

// File: rtl/bp_range_check.sv
module bp_range_check #(
  parameter int ADDR_W = 16
) (
  input  logic [2:0]        bp_code,
  input  logic              from_bottom,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int SHIFT_BASE = ADDR_W - 7;

  logic [ADDR_W-1:0] hi_part;
  logic [ADDR_W-1:0] all_ones;
  int unsigned       sh;

  always_comb begin
    sh       = SHIFT_BASE + int'(bp_code);
    hi_part  = addr >> sh;
    all_ones = (ADDR_W'(1) << (7 - int'(bp_code))) - ADDR_W'(1);
    case (bp_code)
      3'd0:    hit = 1'b0;
      3'd7:    hit = 1'b1;
      default: hit = from_bottom ? (hi_part == '0) : (hi_part == all_ones);
    endcase
  end
endmodule

// File: rtl/bp_regs.sv
module bp_regs
  import flash_bp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_op,
  input  logic [7:0] wr_sr,
  input  logic [7:0] wr_cr,
  input  logic       wp_n,
  input  logic       prog_rej,
  input  logic       erase_rej,
  output logic [7:0] status,
  output logic [7:0] cfg,
  output logic       reg_err
);
  logic            lck_q, pe_q, ee_q, wel_q;
  logic [BP_W-1:0] bp_q;
  logic            bot_q, vol_q, frz_q, err_q;
  logic            wrr_ok, prot_change;

  assign wrr_ok = wel_q && !(lck_q && !wp_n);
  assign prot_change = (wr_sr[SR_BPH:SR_BPL] != bp_q) ||
                       (wr_cr[CR_BOT] && !bot_q) ||
                       (wr_cr[CR_VOL] && !vol_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      lck_q <= 1'b0; pe_q <= 1'b0; ee_q <= 1'b0; wel_q <= 1'b0;
      bp_q  <= '0;   bot_q <= 1'b0; vol_q <= 1'b0; frz_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (cmd_valid) begin
        case (cmd_e'(cmd_op))
          CMD_WREN: wel_q <= 1'b1;
          CMD_WRDI: wel_q <= 1'b0;
          CMD_WRR: begin
            if (wrr_ok) begin
              if (frz_q && prot_change) begin
                err_q <= 1'b1;
              end else begin
                lck_q <= wr_sr[SR_LCK];
                bp_q  <= wr_sr[SR_BPH:SR_BPL];
                bot_q <= bot_q | wr_cr[CR_BOT];
                vol_q <= vol_q | wr_cr[CR_VOL];
                frz_q <= frz_q | wr_cr[CR_FRZ];
              end
            end
          end
          CMD_PROG:  if (prog_rej)  pe_q <= 1'b1;
          CMD_ERASE: if (erase_rej) ee_q <= 1'b1;
          CMD_SWRST: wel_q <= 1'b0;
          CMD_HWRST: begin
            wel_q <= 1'b0;
            frz_q <= 1'b0;
          end
          CMD_POR: begin
            wel_q <= 1'b0;
            frz_q <= 1'b0;
            pe_q  <= 1'b0;
            ee_q  <= 1'b0;
            if (vol_q) bp_q <= '1;
          end
          default: ;
        endcase
      end
    end
  end

  assign status  = {lck_q, pe_q, ee_q, bp_q, wel_q, 1'b0};
  assign cfg     = {2'b00, bot_q, 1'b0, vol_q, 2'b00, frz_q};
  assign reg_err = err_q;
endmodule

// File: rtl/flash_bp_ctrl.sv
module flash_bp_ctrl
  import flash_bp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [7:0]        cmd_sr,
  input  logic [7:0]        cmd_cr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wp_n,
  output logic [7:0]        status,
  output logic [7:0]        config_reg,
  output logic              grant,
  output logic              reject,
  output logic              reg_err
);
  logic hit, is_prog, is_erase, is_array;
  logic grant_q, reject_q;

  bp_range_check #(.ADDR_W(ADDR_W)) u_range (
    .bp_code     (status[SR_BPH:SR_BPL]),
    .from_bottom (config_reg[CR_BOT]),
    .addr        (cmd_addr),
    .hit         (hit)
  );

  assign is_prog  = cmd_valid && (cmd_op == CMD_PROG);
  assign is_erase = cmd_valid && (cmd_op == CMD_ERASE);
  assign is_array = is_prog || is_erase;

  bp_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wr_sr     (cmd_sr),
    .wr_cr     (cmd_cr),
    .wp_n      (wp_n),
    .prog_rej  (is_prog && hit),
    .erase_rej (is_erase && hit),
    .status    (status),
    .cfg       (config_reg),
    .reg_err   (reg_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= is_array && !hit;
      reject_q <= is_array && hit;
    end
  end

  assign grant  = grant_q;
  assign reject = reject_q;
endmodule

// File: rtl/flash_bp_ctrl_chk.sv
module flash_bp_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [3:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              wp_n,
  input logic [7:0]        status,
  input logic [7:0]        config_reg,
  input logic              grant,
  input logic              reject
);
  // R3
  grant_reject_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(grant && reject));

  // R3
  array_answer_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == 4'd4 || cmd_op == 4'd5)) |=> (grant || reject));

  // R4
  bot_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    config_reg[5] |=> config_reg[5]);

  // R4
  vol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    config_reg[3] |=> config_reg[3]);

  // R6
  frozen_code_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (config_reg[0] && !(cmd_valid && cmd_op == 4'd8)) |=> $stable(status[4:2]));

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (config_reg[0] && !(cmd_valid && (cmd_op == 4'd7 || cmd_op == 4'd8)))
      |=> config_reg[0]);

  // R8
  wel_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && (cmd_op == 4'd1 || cmd_op == 4'd2 || cmd_op >= 4'd6))
      |=> $stable(status[1]));

  // R9
  pin_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 4'd3 && status[7] && !wp_n)
      |=> ($stable(status[7:2]) && $stable(config_reg)));

  // R1
  full_code_rejects_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 4'd4 && status[4:2] == 3'd7) |=> reject);
endmodule

bind flash_bp_ctrl flash_bp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_addr   (cmd_addr),
  .wp_n       (wp_n),
  .status     (status),
  .config_reg (config_reg),
  .grant      (grant),
  .reject     (reject)
);

// File: tb/test_flash_bp_ctrl.sv
module test_flash_bp_ctrl;
  localparam int AW = 16;
  localparam logic [3:0] NOP = 4'd0, WREN = 4'd1, WRDI = 4'd2, WRR = 4'd3,
    PROG = 4'd4, ERASE = 4'd5, SWRST = 4'd6, HWRST = 4'd7, POR = 4'd8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = NOP;
  logic [7:0] cmd_sr = '0, cmd_cr = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic wp_n = 1'b1;
  logic [7:0] status, config_reg;
  logic grant, reject, reg_err;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_bp_ctrl #(.ADDR_W(AW)) i_flash_bp_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sr(cmd_sr), .cmd_cr(cmd_cr), .cmd_addr(cmd_addr), .wp_n(wp_n),
    .status(status), .config_reg(config_reg), .grant(grant),
    .reject(reject), .reg_err(reg_err));

  // {erase, code[2:0], bottom, addr[15:0], expect_reject}
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 3'd0, 1'b0, 16'hFFFF, 1'b0},
    {1'b0, 3'd1, 1'b0, 16'hFC00, 1'b1},
    {1'b1, 3'd1, 1'b0, 16'hFBFF, 1'b0},
    {1'b1, 3'd3, 1'b0, 16'hF000, 1'b1},
    {1'b0, 3'd3, 1'b0, 16'hEFFF, 1'b0},
    {1'b0, 3'd6, 1'b0, 16'h8000, 1'b1},
    {1'b1, 3'd6, 1'b0, 16'h7FFF, 1'b0},
    {1'b1, 3'd7, 1'b0, 16'h0000, 1'b1},
    {1'b0, 3'd1, 1'b1, 16'h03FF, 1'b1},
    {1'b1, 3'd1, 1'b1, 16'h0400, 1'b0},
    {1'b0, 3'd5, 1'b1, 16'h3FFF, 1'b1},
    {1'b1, 3'd5, 1'b1, 16'h4000, 1'b0},
    {1'b0, 3'd0, 1'b1, 16'h0000, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [7:0] sr,
                     input logic [7:0] cr, input logic [AW-1:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sr = sr; cmd_cr = cr; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = NOP;
  endtask

  task automatic wrr(input logic [7:0] sr, input logic [7:0] cr);
    cmd(WREN, 8'h00, 8'h00, '0);
    cmd(WRR, sr, cr, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 status", status, 8'h00);
    check("R10 config", config_reg, 8'h00);
    check("R10 outputs", {5'b0, grant, reject, reg_err}, 8'h00);

    // R8 write enable latch behaviour
    cmd(WREN, 8'h00, 8'h00, '0);
    check("R8 wel set", status, 8'h02);
    cmd(WRDI, 8'h00, 8'h00, '0);
    check("R8 wel clear", status, 8'h00);
    cmd(WRR, 8'h08, 8'h00, '0);
    check("R8 wrr without wel", status, 8'h00);
    wrr(8'h08, 8'h00);
    check("R8 wrr keeps wel", status, 8'h0A);

    // R1 R2 R3 table sweep
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      logic [7:0] sr_exp;
      v = VEC[i];
      wrr({3'b000, v[20:18], 2'b00}, {2'b00, v[17], 5'b0});
      check("R1 R2 code stored", {5'b0, status[4:2]}, {5'b0, v[20:18]});
      cmd(v[21] ? ERASE : PROG, 8'h00, 8'h00, v[16:1]);
      check(v[17] ? "R2 range" : "R1 range", {6'b0, grant, reject}, {6'b0, !v[0], v[0]});
      if (v[0]) begin
        sr_exp = v[21] ? 8'h20 : 8'h40;
        check("R3 error flag", status & sr_exp, sr_exp);
      end
    end
    check("R3 both flags sticky", status & 8'h60, 8'h60);

    // R4 one-time-programmable selector
    wrr(8'h00, 8'h00);
    check("R4 bottom stays set", config_reg & 8'h20, 8'h20);

    // R6 R7 lock
    wrr(8'h08, 8'h21);
    check("R6 lock set", config_reg, 8'h21);
    wrr(8'h10, 8'h21);
    check("R6 reg_err pulse", {7'b0, reg_err}, 8'h01);
    check("R6 code unchanged", {5'b0, status[4:2]}, 8'h02);
    wrr(8'h08, 8'h29);
    check("R6 vol not set", config_reg, 8'h21);
    cmd(SWRST, 8'h00, 8'h00, '0);
    check("R7 swrst keeps lock", config_reg, 8'h21);
    check("R8 swrst clears wel", status & 8'h02, 8'h00);
    cmd(HWRST, 8'h00, 8'h00, '0);
    check("R7 hwrst clears lock", config_reg, 8'h20);

    // R5 R11 power-on reset
    wrr(8'h08, 8'h21);
    cmd(POR, 8'h00, 8'h00, '0);
    check("R5 R11 nonvolatile code kept", status, 8'h08);
    check("R11 por config", config_reg, 8'h20);
    wrr(8'h08, 8'h28);
    check("R4 vol set", config_reg, 8'h28);
    cmd(POR, 8'h00, 8'h00, '0);
    check("R5 volatile code reload", status, 8'h1C);
    wrr(8'h08, 8'h00);
    check("R4 vol stays set", config_reg, 8'h28);

    // R9 pin lock
    wrr(8'h88, 8'h00);
    check("R9 lock bit set", status, 8'h8A);
    wp_n = 1'b0;
    cmd(WRR, 8'h00, 8'h00, '0);
    check("R9 ignored with pin low", status, 8'h8A);
    wp_n = 1'b1;
    cmd(WRR, 8'h00, 8'h00, '0);
    check("R9 accepted with pin high", status, 8'h02);
    cmd(POR, 8'h00, 8'h00, '0);
    check("R11 por keeps lock-bit zero", status, 8'h1C);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule